// File: doc/BRIEF.md
# GPIO Interrupt Controller

A 32-pin general-purpose I/O block with a flat 32-bit register file. Software writes an output latch and a per-pin direction mask, and it reads back the synchronized level of every pad. Pins set as outputs drive the latch value. Pins set as inputs leave their pad undriven.

Each pin carries a 2-bit trigger code. A separate per-pin override selects both edges. Every pin has a sticky status bit that is cleared by writing a 1, and a mask bit. Pending bits are the status bits ANDed with the mask bits. They are gathered onto two interrupt request lines, one for each half of the pins.

Access uses a single-cycle strobe. A write takes effect at the clock edge on which `req_i` and `we_i` are both high. Read data is combinational from `addr_i`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Reset clears every register. After reset all pins are inputs, `pad_oe_o` and `pad_o` are zero, all interrupts are masked and `irq_o` is zero.
- R2: Byte offset 0x00 holds the output latch and offset 0x04 holds the direction mask (1 = output). Both read back what was written. `pad_oe_o` equals the direction mask. `pad_o` equals the latch on output pins and is 0 on input pins.
- R3: Offset 0x08 returns the pad levels `pad_i`, delayed by a two-flop synchronizer. A pad change at a clock edge is visible after the second edge and not after the first. Pins set as outputs also report the sampled pad level, not the latch.
- R4: Offset 0x0C holds the trigger codes for pins 0-15: pin n uses bits [2n+1:2n]. Offset 0x10 holds the codes for pins 16-31: pin n uses bits [2(n-16)+1:2(n-16)]. The codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge. Edges are detected on consecutive synchronized samples.
- R5: When a pin's bit at offset 0x1C is 1, the pin triggers on either edge and its 2-bit code is ignored.
- R6: Offset 0x18 is the status register. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R7: A trigger event wins over a clear in the same cycle. A level-triggered bit is set again on every cycle in which its level holds.
- R8: Status bits are set whether or not the pin is masked. Offset 0x14 is the mask, and a 1 enables the pin.
- R9: `irq_o[0]` is the OR of (status AND mask) over pins 0-15. `irq_o[1]` is the same OR over pins 16-31.
- R10: Offset 0x08 is read-only, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pad_i | input | 32 | Pad levels, asynchronous |
| pad_o | output | 32 | Pad drive value |
| pad_oe_o | output | 32 | Pad output enable |
| irq_o | output | 2 | Interrupt requests for pins 0-15 and pins 16-31 |

## Verification
Every pin is swept through all five trigger selections. Each sweep step checks the status bit at points chosen to expose specific faults:
- A swapped code or a misplaced config field sets the wrong bit, or no bit, on a transition.
- An override that does not take precedence leaves the high-level code active while the pad holds steady.
- A clear that beats a same-cycle set loses a level-triggered bit straight after the write.

Separate checks confirm that a write of zeros to the status register keeps the status. They also confirm that a masked pin still latches status while its request line stays low, and that the pad register lags the pad by exactly two edges and ignores the latch on output pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] OFF_DATA   = 5'h00;
  localparam logic [AW-1:0] OFF_DIR    = 5'h04;
  localparam logic [AW-1:0] OFF_PAD    = 5'h08;
  localparam logic [AW-1:0] OFF_CFG_LO = 5'h0C;
  localparam logic [AW-1:0] OFF_CFG_HI = 5'h10;
  localparam logic [AW-1:0] OFF_MASK   = 5'h14;
  localparam logic [AW-1:0] OFF_STAT   = 5'h18;
  localparam logic [AW-1:0] OFF_BOTH   = 5'h1C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o      = s2_q;
  assign q_prev_o = s3_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic [1:0] code_i,
  input  logic       both_i,
  output logic       hit_o
);
  logic rise, fall;
  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    if (both_i) hit_o = rise | fall;
    else begin
      unique case (trig_e'(code_i))
        TRIG_LOW:  hit_o = ~cur_i;
        TRIG_HIGH: hit_o = cur_i;
        TRIG_RISE: hit_o = rise;
        TRIG_FALL: hit_o = fall;
        default:   hit_o = 1'b0;
      endcase
    end
  end

  assert_both_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_i && hit_o) |-> (cur_i != prev_i));

  assert_rise_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_i && code_i == TRIG_RISE && hit_o) |-> (cur_i && !prev_i));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [1:0]       irq_o
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q, status_q;
  logic [NPINS-1:0] pad_lvl, pad_prev, set_evt, pending, clr_vec;
  logic wr, st_wr;

  assign wr    = req_i & we_i;
  assign st_wr = wr & (addr_i == OFF_STAT);

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (pad_i),
    .q_o      (pad_lvl),
    .q_prev_o (pad_prev)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [1:0] code;
    if (n < HALF) begin : g_lo
      assign code = cfg_lo_q[2*n +: 2];
    end else begin : g_hi
      assign code = cfg_hi_q[2*(n-HALF) +: 2];
    end
    gpio_pin_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (pad_lvl[n]),
      .prev_i (pad_prev[n]),
      .code_i (code),
      .both_i (both_q[n]),
      .hit_o  (set_evt[n])
    );
  end

  assign clr_vec = st_wr ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr) begin
        unique case (addr_i)
          OFF_DATA:   data_q   <= wdata_i;
          OFF_DIR:    dir_q    <= wdata_i;
          OFF_CFG_LO: cfg_lo_q <= wdata_i;
          OFF_CFG_HI: cfg_hi_q <= wdata_i;
          OFF_MASK:   mask_q   <= wdata_i;
          OFF_BOTH:   both_q   <= wdata_i;
          default: ;
        endcase
      end
      // set beats clear
      status_q <= (status_q & ~clr_vec) | set_evt;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_DATA:   rdata_o = data_q;
      OFF_DIR:    rdata_o = dir_q;
      OFF_PAD:    rdata_o = pad_lvl;
      OFF_CFG_LO: rdata_o = cfg_lo_q;
      OFF_CFG_HI: rdata_o = cfg_hi_q;
      OFF_MASK:   rdata_o = mask_q;
      OFF_STAT:   rdata_o = status_q;
      OFF_BOTH:   rdata_o = both_q;
      default:    rdata_o = '0;
    endcase
  end

  assign pad_o    = data_q & dir_q;
  assign pad_oe_o = dir_q;
  assign pending  = status_q & mask_q;
  assign irq_o[0] = |pending[HALF-1:0];
  assign irq_o[1] = |pending[NPINS-1:HALF];

  assert_w1c_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> ((status_q & $past(wdata_i & ~set_evt)) == '0));

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_evt) |=> ((status_q & $past(set_evt)) == $past(set_evt)));

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q[HALF-1:0] == '0) |-> !irq_o[0]);

  assert_no_drive_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & ~pad_oe_o) == '0);

  assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic [1:0]  irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    // R1 reset state, read while held in reset
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      if (a != 2) begin
        rd(5'(a * 4), v);
        chk("R1 reg", v, 32'h0);
      end
    end
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 pad_o", pad_out, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    rst_n = 1'b1;

    // R2 latch, direction, drive
    wr(5'h00, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000);
    rd(5'h00, v); chk("R2 data", v, 32'hA5A5_0F0F);
    rd(5'h04, v); chk("R2 dir", v, 32'hFFFF_0000);
    chk("R2 oe", pad_oe, 32'hFFFF_0000);
    chk("R2 pad_o", pad_out, 32'hA5A5_0000);

    // R3 two-edge lag, outputs report the pad not the latch
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(5'h08, v); chk("R3 after one edge", v, 32'h0);
    @(negedge clk);
    rd(5'h08, v); chk("R3 after two edges", v, 32'h1234_5678);

    // R10 pad register is read-only
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R10 pad ro", v, 32'h1234_5678);
    rd(5'h00, v); chk("R10 data kept", v, 32'hA5A5_0F0F);

    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    pad_in = '0;
    repeat (4) @(negedge clk);

    // R8 masked pin still latches, mask gates irq
    wr(5'h0C, 32'hAAAA_AAA8);
    wr(5'h10, 32'hAAAA_AAAA);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd(5'h18, v); chk("R8 masked status", v, 32'h1);
    chk("R8 masked irq", {30'h0, irq}, 32'h0);
    wr(5'h14, 32'h1);
    chk("R8 unmasked irq", {30'h0, irq}, 32'h1);

    // R4/R5/R6/R7/R9 sweep: every pin, every trigger selection (4 = both edges)
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [1:0] code;
        logic [1:0] eirq;
        logic est;
        code = (m == 4) ? 2'd1 : 2'(m);
        lo = 32'hAAAA_AAAA; hi = 32'hAAAA_AAAA;
        if (p < 16) lo[2*p +: 2] = code; else hi[2*(p-16) +: 2] = code;
        wr(5'h0C, lo);
        wr(5'h10, hi);
        wr(5'h1C, (m == 4) ? (32'h1 << p) : 32'h0);
        wr(5'h14, 32'h1 << p);
        // step 1: pad low, clear; low level re-sets at the clearing edge (R7)
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R7 low set wins", v, (m == 0) ? (32'h1 << p) : 32'h0);
        // step 2: rising transition
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in[p] = 1'b1;
        repeat (4) @(negedge clk);
        rd(5'h18, v); chk("R4 rise", v, (m != 3) ? (32'h1 << p) : 32'h0);
        // step 3: clear with pad steady high; only high level re-sets (R5 override)
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R5 steady high", v, (m == 1) ? (32'h1 << p) : 32'h0);
        // step 4: falling transition
        pad_in[p] = 1'b0;
        repeat (4) @(negedge clk);
        est = (m != 2);
        rd(5'h18, v); chk("R4 fall", v, est ? (32'h1 << p) : 32'h0);
        eirq = est ? ((p < 16) ? 2'b01 : 2'b10) : 2'b00;
        chk("R9 irq line", {30'h0, irq}, {30'h0, eirq});
        // writing zero keeps status (R6)
        wr(5'h18, 32'h0);
        rd(5'h18, v); chk("R6 zero write", v, est ? (32'h1 << p) : 32'h0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule